// File: doc/BRIEF.md
# Lock Monitor with Non-Revertive Reference Autoswitch

This block sits beside a clock synthesis loop. It takes three single-cycle edge pulses, all synchronous to a fast sampling clock: one for each of two divided reference clocks and one for the divided feedback clock. It sends the currently active reference onward to a rising-edge gap meter. The meter counts the sampling cycles from whichever edge comes first to the partner edge. If no partner edge arrives within a timeout window, the comparison is scored as out of range.

The gap results drive a loss-of-lock flag. The flag has separate thresholds for setting and for clearing, with a dead band between them. In manual mode a select pin chooses the active reference. In automatic mode a fresh assertion of loss-of-lock moves the block to the other reference. The block never moves back on its own accord. After a move, further moves are masked for a holdoff of a set number of completed comparisons, so the loop can reacquire. An acknowledge output shows which reference is active. A separate path forces the narrow-bandwidth control output inactive while an initialization input is high.

The gap meter is a state machine with states MEAS_IDLE, MEAS_REF_FIRST and MEAS_FB_FIRST. Its transitions are:
- IDLE to REF_FIRST when a reference edge arrives alone.
- IDLE to FB_FIRST when a feedback edge arrives alone.
- REF_FIRST or FB_FIRST back to IDLE when the partner edge arrives, when the timeout expires, or when the active reference changes.

The selector is a state machine with states SEL_MANUAL, SEL_AUTO_RUN and SEL_AUTO_HOLD. Its transitions are:
- MANUAL to AUTO_RUN when the auto-mode input goes high.
- AUTO_RUN to AUTO_HOLD on a loss-of-lock set event, which also swaps the active reference.
- AUTO_HOLD to AUTO_RUN after HOLDOFF completed comparisons.
- Any state to MANUAL when the auto-mode input is low.

Top module: `lock_autoswitch`

## Requirements
- R1: The gap is the number of sampling cycles between the routed reference edge and the feedback edge, in either order. Edges in the same cycle give gap 0. A leading edge whose partner has not arrived after TIMEOUT cycles yields an out-of-range result.
- R2: A comparison with gap greater than SET_GAP, or a timed-out comparison, drives lol to 1. The new value is visible two cycles after the cycle of the partner edge.
- R3: A comparison with gap less than CLR_GAP drives lol to 0.
- R4: A comparison with gap from CLR_GAP to SET_GAP inclusive leaves lol unchanged. Between comparisons lol does not change.
- R5: During and after reset, lol is 1 and ref_ack equals sel_pin.
- R6: With auto_en low, ref_ack equals the sel_pin value of the previous cycle (0 means ref0_pls, 1 means ref1_pls). Only the selected input's edges reach the gap meter.
- R7: With auto_en high, a comparison that moves lol from 0 to 1 toggles ref_ack on the next cycle. With auto_en high and no such event, ref_ack holds.
- R8: After an automatic swap, ref_ack stays on the new reference while both references give in-lock results.
- R9: For HOLDOFF completed comparisons after a swap, lol rising events cause no swap. After that, the next lol rising event swaps again.
- R10: If auto_en is low in the same cycle as a lol set event, manual selection wins and ref_ack follows sel_pin.
- R11: nbw_out is 0 while init_pin is 1. Otherwise nbw_out equals nbw_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref0_pls | input | 1 | Rising-edge pulse of divided reference 0 |
| ref1_pls | input | 1 | Rising-edge pulse of divided reference 1 |
| fb_pls | input | 1 | Rising-edge pulse of divided feedback clock |
| auto_en | input | 1 | 1 selects automatic switching |
| sel_pin | input | 1 | Manual reference choice |
| init_pin | input | 1 | Power-up initialization, forces narrow bandwidth off |
| nbw_req | input | 1 | Narrow-bandwidth request |
| lol | output | 1 | Loss-of-lock flag |
| ref_ack | output | 1 | Active reference (0 or 1) |
| nbw_out | output | 1 | Narrow-bandwidth control |

## Verification
A loss-of-lock set event and a drop of the auto-mode input can land in the same cycle. The selector must then resolve a swap request against a manual override. The bench provokes this by releasing auto_en on the exact cycle after an out-of-range partner edge, when the set event is evaluated. It samples ref_ack one cycle later: it must still equal sel_pin, with no transient toggle. Holdoff expiry and a set event are a second overlap. The bench times a bad comparison both inside and just after the holdoff window and checks whether a swap occurs.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        MEAS_IDLE      = 2'd0,
        MEAS_REF_FIRST = 2'd1,
        MEAS_FB_FIRST  = 2'd2
    } meas_state_t;

    typedef enum logic [1:0] {
        SEL_MANUAL    = 2'd0,
        SEL_AUTO_RUN  = 2'd1,
        SEL_AUTO_HOLD = 2'd2
    } sel_state_t;

endpackage

// File: rtl/gap_meter.sv
module gap_meter
    import lock_pkg::*;
#(
    parameter int TIMEOUT = 20,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_pls,
    input  logic             fb_pls,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_gap,
    output logic             meas_timeout
);

    meas_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             res_v, res_to;
    logic [CNT_W-1:0] res_gap;
    logic             partner;

    assign partner = (state_q == MEAS_REF_FIRST) ? fb_pls : ref_pls;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MEAS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        res_v   = 1'b0;
        res_to  = 1'b0;
        res_gap = cnt_q;
        unique case (state_q)
            MEAS_IDLE: begin
                if (ref_pls && fb_pls) begin
                    res_v   = 1'b1;
                    res_gap = '0;
                end else if (ref_pls) begin
                    state_d = MEAS_REF_FIRST;
                    cnt_d   = CNT_W'(1);
                end else if (fb_pls) begin
                    state_d = MEAS_FB_FIRST;
                    cnt_d   = CNT_W'(1);
                end
            end
            MEAS_REF_FIRST, MEAS_FB_FIRST: begin
                if (partner) begin
                    res_v   = 1'b1;
                    state_d = MEAS_IDLE;
                end else if (cnt_q == CNT_W'(TIMEOUT)) begin
                    res_v   = 1'b1;
                    res_to  = 1'b1;
                    state_d = MEAS_IDLE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = MEAS_IDLE;
        endcase
        if (clr) begin
            state_d = MEAS_IDLE;
            res_v   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_valid   <= 1'b0;
            meas_gap     <= '0;
            meas_timeout <= 1'b0;
        end else begin
            meas_valid   <= res_v;
            meas_gap     <= res_gap;
            meas_timeout <= res_to;
        end
    end

endmodule

// File: rtl/lol_tracker.sv
module lol_tracker #(
    parameter int SET_GAP = 6,
    parameter int CLR_GAP = 3,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_gap,
    input  logic             meas_timeout,
    output logic             lol,
    output logic             gap_over,
    output logic             gap_under,
    output logic             set_evt
);

    assign gap_over  = meas_timeout || (meas_gap > CNT_W'(SET_GAP));
    assign gap_under = !meas_timeout && (meas_gap < CNT_W'(CLR_GAP));
    assign set_evt   = meas_valid && gap_over && !lol;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol <= 1'b1;
        end else if (meas_valid) begin
            if (gap_over)
                lol <= 1'b1;
            else if (gap_under)
                lol <= 1'b0;
        end
    end

endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import lock_pkg::*;
#(
    parameter int HOLDOFF = 4,
    parameter int HOLD_W  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic sel_pin,
    input  logic set_evt,
    input  logic meas_valid,
    output logic active,
    output logic sel_change,
    output logic in_auto,
    output logic in_hold
);

    sel_state_t        state_q, state_d;
    logic              active_d;
    logic [HOLD_W-1:0] hold_q, hold_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= auto_en ? SEL_AUTO_RUN : SEL_MANUAL;
            active  <= sel_pin;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            active  <= active_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        active_d = active;
        hold_d   = hold_q;
        unique case (state_q)
            SEL_MANUAL: begin
                active_d = sel_pin;
                if (auto_en)
                    state_d = SEL_AUTO_RUN;
            end
            SEL_AUTO_RUN: begin
                if (!auto_en) begin
                    state_d  = SEL_MANUAL;
                    active_d = sel_pin;
                end else if (set_evt) begin
                    state_d  = SEL_AUTO_HOLD;
                    active_d = ~active;
                    hold_d   = '0;
                end
            end
            SEL_AUTO_HOLD: begin
                if (!auto_en) begin
                    state_d  = SEL_MANUAL;
                    active_d = sel_pin;
                end else if (meas_valid) begin
                    if (hold_q == HOLD_W'(HOLDOFF - 1))
                        state_d = SEL_AUTO_RUN;
                    else
                        hold_d = hold_q + HOLD_W'(1);
                end
            end
            default: begin
                state_d  = SEL_MANUAL;
                active_d = sel_pin;
            end
        endcase
    end

    assign sel_change = (active_d != active);
    assign in_auto    = (state_q != SEL_MANUAL);
    assign in_hold    = (state_q == SEL_AUTO_HOLD);

endmodule

// File: rtl/lock_autoswitch.sv
module lock_autoswitch #(
    parameter int SET_GAP = 6,
    parameter int CLR_GAP = 3,
    parameter int TIMEOUT = 20,
    parameter int HOLDOFF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref0_pls,
    input  logic ref1_pls,
    input  logic fb_pls,
    input  logic auto_en,
    input  logic sel_pin,
    input  logic init_pin,
    input  logic nbw_req,
    output logic lol,
    output logic ref_ack,
    output logic nbw_out
);

    localparam int CNT_W  = $clog2(TIMEOUT + 1);
    localparam int HOLD_W = $clog2(HOLDOFF + 1);

    logic             routed_ref;
    logic             meas_valid, meas_timeout;
    logic [CNT_W-1:0] meas_gap;
    logic             gap_over, gap_under, set_evt;
    logic             sel_change, in_auto, in_hold;

    assign routed_ref = ref_ack ? ref1_pls : ref0_pls;
    assign nbw_out    = nbw_req && !init_pin;

    gap_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (sel_change),
        .ref_pls      (routed_ref),
        .fb_pls       (fb_pls),
        .meas_valid   (meas_valid),
        .meas_gap     (meas_gap),
        .meas_timeout (meas_timeout)
    );

    lol_tracker #(.SET_GAP(SET_GAP), .CLR_GAP(CLR_GAP), .CNT_W(CNT_W)) u_lol (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_valid   (meas_valid),
        .meas_gap     (meas_gap),
        .meas_timeout (meas_timeout),
        .lol          (lol),
        .gap_over     (gap_over),
        .gap_under    (gap_under),
        .set_evt      (set_evt)
    );

    ref_selector #(.HOLDOFF(HOLDOFF), .HOLD_W(HOLD_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .sel_pin    (sel_pin),
        .set_evt    (set_evt),
        .meas_valid (meas_valid),
        .active     (ref_ack),
        .sel_change (sel_change),
        .in_auto    (in_auto),
        .in_hold    (in_hold)
    );

endmodule

// File: rtl/lock_autoswitch_chk.sv
module lock_autoswitch_chk (
    input logic clk,
    input logic rst_n,
    input logic auto_en,
    input logic sel_pin,
    input logic lol,
    input logic ref_ack,
    input logic meas_valid,
    input logic gap_over,
    input logic gap_under,
    input logic set_evt,
    input logic in_auto,
    input logic in_hold
);

    p_lol_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && gap_over) |=> lol);

    p_lol_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && gap_under) |=> !lol);

    p_lol_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid || (!gap_over && !gap_under)) |=> $stable(lol));

    p_manual_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (ref_ack == $past(sel_pin)));

    p_swap_only_on_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_auto && auto_en && !set_evt) |=> $stable(ref_ack));

    p_hold_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && auto_en) |=> $stable(ref_ack));

endmodule

bind lock_autoswitch lock_autoswitch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .sel_pin    (sel_pin),
    .lol        (lol),
    .ref_ack    (ref_ack),
    .meas_valid (meas_valid),
    .gap_over   (gap_over),
    .gap_under  (gap_under),
    .set_evt    (set_evt),
    .in_auto    (in_auto),
    .in_hold    (in_hold)
);

// File: tb/lock_autoswitch_bench.sv
module lock_autoswitch_bench;

    localparam int SET_GAP = 6;
    localparam int CLR_GAP = 3;
    localparam int TIMEOUT = 20;
    localparam int HOLDOFF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref0_pls = 1'b0, ref1_pls = 1'b0, fb_pls = 1'b0;
    logic auto_en = 1'b0, sel_pin = 1'b0, init_pin = 1'b0, nbw_req = 1'b0;
    logic lol, ref_ack, nbw_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [1:0] mask = 2'b01;

    always #2 clk = ~clk;

    lock_autoswitch #(.SET_GAP(SET_GAP), .CLR_GAP(CLR_GAP),
                      .TIMEOUT(TIMEOUT), .HOLDOFF(HOLDOFF)) u_lock_autoswitch (
        .clk(clk), .rst_n(rst_n), .ref0_pls(ref0_pls), .ref1_pls(ref1_pls),
        .fb_pls(fb_pls), .auto_en(auto_en), .sel_pin(sel_pin),
        .init_pin(init_pin), .nbw_req(nbw_req), .lol(lol),
        .ref_ack(ref_ack), .nbw_out(nbw_out)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_ref(input logic v);
        ref0_pls = v && mask[0];
        ref1_pls = v && mask[1];
    endtask

    // one comparison; fb_first selects the leader, k is the gap in cycles
    task automatic pair(input bit fb_first, input int k);
        if (k == 0) begin
            put_ref(1'b1); fb_pls = 1'b1;
            @(negedge clk);
            put_ref(1'b0); fb_pls = 1'b0;
        end else begin
            if (fb_first) fb_pls = 1'b1; else put_ref(1'b1);
            @(negedge clk);
            fb_pls = 1'b0; put_ref(1'b0);
            repeat (k - 1) @(negedge clk);
            if (fb_first) put_ref(1'b1); else fb_pls = 1'b1;
            @(negedge clk);
            fb_pls = 1'b0; put_ref(1'b0);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(input logic s, input logic a);
        sel_pin = s; auto_en = a; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R5: reset state
        do_reset(1'b0, 1'b0);
        chk(lol, 1, "R5 lol after reset");
        chk(ref_ack, 0, "R5 ack after reset sel=0");

        // R1 R2 R3 R4: sweep gap and leader from both flag states
        mask = 2'b01;
        for (int k = 0; k <= TIMEOUT; k++) begin
            for (int lead = 0; lead < 2; lead++) begin
                pair(1'b0, 0);
                pair(lead[0], k);
                chk(lol, (k > SET_GAP) ? 1 : 0, $sformatf("R1/R2/R4 from 0 gap %0d lead %0d", k, lead));
                pair(1'b0, SET_GAP + 1);
                pair(lead[0], k);
                chk(lol, (k < CLR_GAP) ? 0 : 1, $sformatf("R1/R3/R4 from 1 gap %0d lead %0d", k, lead));
            end
        end

        // R1 timeout: leader with no partner
        pair(1'b0, 0);
        put_ref(1'b1); @(negedge clk); put_ref(1'b0);
        repeat (TIMEOUT + 2) @(negedge clk);
        chk(lol, 1, "R1 timeout with missing partner");

        // R6: manual select and routing
        sel_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk(ref_ack, 1, "R6 ack follows sel");
        mask = 2'b10;
        pair(1'b0, 0);
        chk(lol, 0, "R6 selected input reaches meter");
        mask = 2'b01;
        pair(1'b0, 0);
        repeat (TIMEOUT + 4) @(negedge clk);
        chk(lol, 1, "R6 unselected input ignored");
        sel_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk(ref_ack, 0, "R6 ack back to 0");

        // R5 with sel=1
        do_reset(1'b1, 1'b0);
        chk(ref_ack, 1, "R5 ack after reset sel=1");

        // R7 R8 R9: automatic swap, holdoff, non-revertive
        do_reset(1'b0, 1'b1);
        mask = 2'b01;
        pair(1'b0, 0);
        chk(lol, 0, "R7 locked on ref0");
        pair(1'b0, SET_GAP + 2);
        chk(lol, 1, "R2 lol set before swap");
        chk(ref_ack, 1, "R7 swap to ref1");
        mask = 2'b11;
        pair(1'b0, 0);                 // hold comparison 1
        chk(lol, 0, "R8 relock on ref1");
        pair(1'b1, SET_GAP + 3);       // hold comparison 2, masked
        chk(lol, 1, "R9 lol set in holdoff");
        chk(ref_ack, 1, "R9 no swap inside holdoff");
        pair(1'b0, 0);                 // hold comparison 3
        pair(1'b0, 0);                 // hold comparison 4, holdoff ends
        chk(ref_ack, 1, "R8 non-revertive with both refs good");
        pair(1'b0, 0);
        chk(ref_ack, 1, "R8 still on ref1");
        pair(1'b0, SET_GAP + 1);
        chk(ref_ack, 0, "R9 swap after holdoff");

        // R10: auto drop coincident with set event
        do_reset(1'b1, 1'b1);
        mask = 2'b10;
        pair(1'b0, 0);
        chk(lol, 0, "R10 locked on ref1");
        put_ref(1'b1); @(negedge clk); put_ref(1'b0);
        repeat (SET_GAP) @(negedge clk);
        fb_pls = 1'b1;                 // partner, gap SET_GAP+1
        @(negedge clk);
        fb_pls = 1'b0;
        auto_en = 1'b0;                // sampled with the set event
        @(negedge clk);
        chk(ref_ack, 1, "R10 manual wins over swap");
        chk(lol, 1, "R10 lol still set");

        // R11: narrow-bandwidth override
        for (int v = 0; v < 4; v++) begin
            init_pin = v[1]; nbw_req = v[0];
            #1;
            chk(nbw_out, (v[0] && !v[1]) ? 1 : 0, $sformatf("R11 init=%0d req=%0d", v[1], v[0]));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule